// File: doc/BRIEF.md
# Wait-State Parallel Bus Cycle Master

This block is a master that runs single read or write cycles on a narrow parallel bus, one at a time. A request names the direction, whether the target lives in memory space or in I/O space, the address and, for writes, one data byte. The master then walks a clocked sequence of four phases (C1, C2, C3, C4). It pulses an address-latch strobe in C1. It asserts exactly one active-low command strobe from C2 through C3. It releases every strobe in C4, where it also reports completion.

A slow target can stretch the cycle by holding the ready line low when it is sampled at the edge that closes C2. The master then inserts wait phases between C2 and C3 until ready is seen high again. The number of wait phases per cycle has a hard cap. When the cap is reached with ready still low, the cycle completes anyway and is flagged as timed out. Memory accesses use the full address width and the memory strobes. I/O accesses use a narrower address field, with the upper lines driven to zero, and the I/O strobes.

Top module: `bus_cycle_master`

## Requirements
- R1: After reset, all four command strobes are high, the latch strobe, data-enable, done, timeout and busy are low.
- R2: A request is accepted only while busy is low. On the clock after acceptance the cycle is in C1, and the latch strobe is high for that single clock only. With ready high at the end of C2, done is high in the fourth clock after acceptance (C1, C2, C3, C4).
- R3: Ready is sampled at the clock edge that ends C2 and at each edge that ends a wait phase. Each low sample adds one wait phase between C2 and C3. The first high sample moves the cycle to C3.
- R4: At most MAX_WAITS (6 by default) wait phases are added. If ready is still low when the last one ends, the cycle proceeds to C3 and C4 and timeout is high together with done. Otherwise timeout is low with done.
- R5: A memory access drives the full 20-bit request address on the bus address lines from C1 through C4. A read asserts only the memory-read strobe and a write asserts only the memory-write strobe (low) from C2 through C3, including any wait phases.
- R6: An I/O access drives the low 16 request address bits, with the upper 4 bus address lines at zero. A read asserts only the I/O-read strobe and a write asserts only the I/O-write strobe, with the same phase window as R5.
- R7: On a write, data-enable is high and the write byte is on the data-out lines from C2 through C4. Data-enable is low in C1, on reads and when idle.
- R8: On a read, the data-in byte present in C3, after ready has been seen high or the cap has been reached, is captured at the end of C3. It is shown on rdata while done is high.
- R9: At most one command strobe is low at any time, and all are high in C4 and while idle.
- R10: Busy is high from C1 through C4. A request raised while busy has no effect: the cycle in progress keeps its address, and busy falls after C4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a cycle (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | MEM_AW (20) | Target address |
| req_wdata | input | DW (8) | Write byte |
| busy | output | 1 | A cycle is in progress |
| bus_ale | output | 1 | Address-latch strobe, high in C1 |
| bus_addr | output | MEM_AW (20) | Bus address lines |
| bus_dout | output | DW (8) | Write data lines |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | DW (8) | Read data lines from the target |
| bus_memr_n | output | 1 | Memory read strobe, active low |
| bus_memw_n | output | 1 | Memory write strobe, active low |
| bus_ior_n | output | 1 | I/O read strobe, active low |
| bus_iow_n | output | 1 | I/O write strobe, active low |
| bus_rdy | input | 1 | Target ready |
| done | output | 1 | One-clock completion pulse in C4 |
| rdata | output | DW (8) | Captured read byte |
| timeout | output | 1 | Wait cap reached, valid with done |

## Verification
The bench builds the block with its defaults: a 20-bit memory address, a 16-bit I/O address, 8-bit data and a cap of six wait phases. The small cap lets random low-ready stretches of zero to eight samples cover every wait count, the exact-cap case and the over-cap timeout within a few clocks per cycle. The 4-bit gap between the two address widths makes the zeroed upper lines on I/O cycles observable.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_C1   = 3'd1,
    PH_C2   = 3'd2,
    PH_WAIT = 3'd3,
    PH_C3   = 3'd4,
    PH_C4   = 3'd5
  } phase_t;

  // strobe index = {is_io, is_write}
  localparam int STB_MEMR = 0;
  localparam int STB_MEMW = 1;
  localparam int STB_IOR  = 2;
  localparam int STB_IOW  = 3;
  localparam int NUM_STB  = 4;

  function automatic logic cmd_window(phase_t p);
    return (p == PH_C2) || (p == PH_WAIT) || (p == PH_C3);
  endfunction

  function automatic logic drive_window(phase_t p);
    return (p == PH_C2) || (p == PH_WAIT) || (p == PH_C3) || (p == PH_C4);
  endfunction

endpackage

// File: rtl/bcm_phase_fsm.sv
module bcm_phase_fsm
  import bcm_pkg::*;
#(
  parameter int MAX_WAITS = 6
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   bus_rdy,
  output phase_t phase_q,
  output phase_t phase_nxt,
  output logic   cap_hit_q
);

  localparam int WCW = (MAX_WAITS < 1) ? 1 : $clog2(MAX_WAITS + 1);
  localparam logic [WCW-1:0] CAP = WCW'(MAX_WAITS);
  localparam bit HAS_WAITS = (MAX_WAITS > 0);

  logic [WCW-1:0] wait_cnt_q;
  logic           at_cap;
  logic           cap_exit;

  assign at_cap = (wait_cnt_q == CAP);

  always_comb begin
    phase_nxt = phase_q;
    cap_exit  = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (start) phase_nxt = PH_C1;
      PH_C1:   phase_nxt = PH_C2;
      PH_C2: begin
        if (bus_rdy) begin
          phase_nxt = PH_C3;
        end else if (HAS_WAITS) begin
          phase_nxt = PH_WAIT;
        end else begin
          phase_nxt = PH_C3;
          cap_exit  = 1'b1;
        end
      end
      PH_WAIT: begin
        if (bus_rdy) begin
          phase_nxt = PH_C3;
        end else if (at_cap) begin
          phase_nxt = PH_C3;
          cap_exit  = 1'b1;
        end
      end
      PH_C3:   phase_nxt = PH_C4;
      PH_C4:   phase_nxt = PH_IDLE;
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      wait_cnt_q <= '0;
      cap_hit_q  <= 1'b0;
    end else begin
      phase_q <= phase_nxt;
      if (start) begin
        cap_hit_q  <= 1'b0;
        wait_cnt_q <= '0;
      end else if (cap_exit) begin
        cap_hit_q <= 1'b1;
      end
      if (phase_q == PH_C2 && phase_nxt == PH_WAIT) begin
        wait_cnt_q <= WCW'(1);
      end else if (phase_q == PH_WAIT && phase_nxt == PH_WAIT) begin
        wait_cnt_q <= wait_cnt_q + WCW'(1);
      end
    end
  end

  // R4: the wait counter never passes the cap
  p_wait_cap_r4: assert property (@(posedge clk) disable iff (rst)
    wait_cnt_q <= CAP);

  // R3: a high ready sample in a wait phase leads straight to C3
  p_wait_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_WAIT && bus_rdy) |=> (phase_q == PH_C3));

  // R3: a low ready sample at the end of C2 opens a wait phase
  p_c2_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (HAS_WAITS && phase_q == PH_C2 && !bus_rdy) |=> (phase_q == PH_WAIT));

  // R2: C1 is always followed by C2
  p_c1_to_c2_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_C1) |=> (phase_q == PH_C2));

endmodule

// File: rtl/bcm_strobe_decode.sv
module bcm_strobe_decode
  import bcm_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase_nxt,
  input  logic   io_nxt,
  input  logic   write_nxt,
  output logic   ale,
  output logic   memr_n,
  output logic   memw_n,
  output logic   ior_n,
  output logic   iow_n,
  output logic   doe,
  output logic   done
);

  logic [1:0]         kind_idx;
  logic [NUM_STB-1:0] act;
  logic [NUM_STB-1:0] stb_n_q;

  assign kind_idx = {io_nxt, write_nxt};

  for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
    assign act[g] = cmd_window(phase_nxt) && (kind_idx == 2'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_n_q <= '1;
      ale     <= 1'b0;
      doe     <= 1'b0;
      done    <= 1'b0;
    end else begin
      stb_n_q <= ~act;
      ale     <= (phase_nxt == PH_C1);
      doe     <= drive_window(phase_nxt) && write_nxt;
      done    <= (phase_nxt == PH_C4);
    end
  end

  assign memr_n = stb_n_q[STB_MEMR];
  assign memw_n = stb_n_q[STB_MEMW];
  assign ior_n  = stb_n_q[STB_IOR];
  assign iow_n  = stb_n_q[STB_IOW];

  // R9: never more than one command strobe low
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    $countones(~stb_n_q) <= 1);

  // R2: latch strobe lasts one clock
  p_ale_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  // R9: strobes are released in the completion phase
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (stb_n_q == '1));

endmodule

// File: rtl/bcm_data_path.sv
module bcm_data_path
  import bcm_pkg::*;
#(
  parameter int MEM_AW = 20,
  parameter int IO_AW  = 16,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  phase_t            phase_q,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [MEM_AW-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [DW-1:0]     bus_din,
  output logic              io_q,
  output logic              write_q,
  output logic [MEM_AW-1:0] bus_addr,
  output logic [DW-1:0]     bus_dout,
  output logic [DW-1:0]     rdata
);

  localparam int HI_W = MEM_AW - IO_AW;

  logic [MEM_AW-1:0] addr_shaped;

  if (HI_W > 0) begin : g_narrow_io
    assign addr_shaped = req_io ? {{HI_W{1'b0}}, req_addr[IO_AW-1:0]} : req_addr;
  end else begin : g_same_width
    assign addr_shaped = req_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_q     <= 1'b0;
      write_q  <= 1'b0;
      bus_addr <= '0;
      bus_dout <= '0;
      rdata    <= '0;
    end else begin
      if (start) begin
        io_q     <= req_io;
        write_q  <= req_write;
        bus_addr <= addr_shaped;
        bus_dout <= req_wdata;
      end
      if (phase_q == PH_C3 && !write_q) begin
        rdata <= bus_din;
      end
    end
  end

  // R10: the address holds through the cycle once latched
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_C2 || phase_q == PH_WAIT || phase_q == PH_C3 || phase_q == PH_C4)
      |-> $stable(bus_addr));

  // R8: captured read byte stays put outside the capture edge
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_C4) |=> $stable(rdata));

endmodule

// File: rtl/bus_cycle_master.sv
module bus_cycle_master
  import bcm_pkg::*;
#(
  parameter int MEM_AW    = 20,
  parameter int IO_AW     = 16,
  parameter int DW        = 8,
  parameter int MAX_WAITS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [MEM_AW-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              busy,
  output logic              bus_ale,
  output logic [MEM_AW-1:0] bus_addr,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_doe,
  input  logic [DW-1:0]     bus_din,
  output logic              bus_memr_n,
  output logic              bus_memw_n,
  output logic              bus_ior_n,
  output logic              bus_iow_n,
  input  logic              bus_rdy,
  output logic              done,
  output logic [DW-1:0]     rdata,
  output logic              timeout
);

  phase_t phase_q;
  phase_t phase_nxt;
  logic   cap_hit_q;
  logic   start;
  logic   io_q;
  logic   write_q;
  logic   io_nxt;
  logic   write_nxt;

  assign start     = req_valid && (phase_q == PH_IDLE);
  assign io_nxt    = start ? req_io : io_q;
  assign write_nxt = start ? req_write : write_q;
  assign busy      = (phase_q != PH_IDLE);
  assign timeout   = done && cap_hit_q;

  bcm_phase_fsm #(.MAX_WAITS(MAX_WAITS)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .bus_rdy   (bus_rdy),
    .phase_q   (phase_q),
    .phase_nxt (phase_nxt),
    .cap_hit_q (cap_hit_q)
  );

  bcm_strobe_decode u_stb (
    .clk       (clk),
    .rst       (rst),
    .phase_nxt (phase_nxt),
    .io_nxt    (io_nxt),
    .write_nxt (write_nxt),
    .ale       (bus_ale),
    .memr_n    (bus_memr_n),
    .memw_n    (bus_memw_n),
    .ior_n     (bus_ior_n),
    .iow_n     (bus_iow_n),
    .doe       (bus_doe),
    .done      (done)
  );

  bcm_data_path #(.MEM_AW(MEM_AW), .IO_AW(IO_AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .phase_q   (phase_q),
    .req_write (req_write),
    .req_io    (req_io),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .bus_din   (bus_din),
    .io_q      (io_q),
    .write_q   (write_q),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout),
    .rdata     (rdata)
  );

  // R8: done is a single-clock pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: timeout only appears alongside done
  p_timeout_done_r4: assert property (@(posedge clk) disable iff (rst)
    timeout |-> done);

  // R7: data is never driven during a read cycle
  p_no_drive_read_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !write_q) |-> !bus_doe);

  // R10: after completion the master returns to idle
  p_idle_after_done_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

endmodule

// File: tb/bus_cycle_master_bench.sv
module bus_cycle_master_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW = 20;
  localparam int IO_AW  = 16;
  localparam int DW     = 8;
  localparam int MAX_WAITS = 6;

  logic              clk = 1'b0;
  logic              rst;
  logic              req_valid, req_write, req_io;
  logic [MEM_AW-1:0] req_addr;
  logic [DW-1:0]     req_wdata;
  logic              busy, bus_ale, bus_doe;
  logic [MEM_AW-1:0] bus_addr;
  logic [DW-1:0]     bus_dout, bus_din, rdata;
  logic              bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n;
  logic              bus_rdy, done, timeout;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_master #(.MEM_AW(MEM_AW), .IO_AW(IO_AW), .DW(DW), .MAX_WAITS(MAX_WAITS))
  u_bus_cycle_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .bus_ale(bus_ale), .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .bus_memr_n(bus_memr_n), .bus_memw_n(bus_memw_n),
    .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n), .bus_rdy(bus_rdy), .done(done),
    .rdata(rdata), .timeout(timeout)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] strobes();
    return {bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n};
  endfunction

  // {memr_n, memw_n, ior_n, iow_n} with the selected one low
  function automatic logic [3:0] exp_strobes(input bit io, input bit wr);
    if (!io && !wr) return 4'b0111;
    if (!io &&  wr) return 4'b1011;
    if ( io && !wr) return 4'b1101;
    return 4'b1110;
  endfunction

  function automatic logic [MEM_AW-1:0] exp_addr(input bit io, input logic [MEM_AW-1:0] a);
    return io ? {{(MEM_AW-IO_AW){1'b0}}, a[IO_AW-1:0]} : a;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_txn(input bit wr, input bit io, input logic [MEM_AW-1:0] a,
                         input logic [DW-1:0] wd, input int nlow,
                         input logic [DW-1:0] rd, input bit poke_busy);
    int ew;
    logic [MEM_AW-1:0] ea;
    ew = (nlow > MAX_WAITS) ? MAX_WAITS : nlow;
    ea = exp_addr(io, a);
    req_valid = 1'b1; req_write = wr; req_io = io; req_addr = a; req_wdata = wd;
    bus_rdy = (nlow == 0);
    bus_din = ~rd;
    step();
    req_valid = 1'b0;
    // C1
    chk(bus_ale == 1'b1, "R2", "ale in C1", bus_ale, 1);
    chk(strobes() == 4'b1111, "R9", "strobes in C1", strobes(), 4'hf);
    chk(bus_addr == ea, io ? "R6" : "R5", "address", bus_addr, ea);
    chk(busy == 1'b1, "R10", "busy in C1", busy, 1);
    chk(bus_doe == 1'b0, "R7", "doe in C1", bus_doe, 0);
    step();
    // C2
    chk(bus_ale == 1'b0, "R2", "ale after C1", bus_ale, 0);
    chk(strobes() == exp_strobes(io, wr), io ? "R6" : "R5", "strobe in C2",
        strobes(), exp_strobes(io, wr));
    chk(bus_doe == wr, "R7", "doe in C2", bus_doe, wr);
    if (poke_busy) begin
      req_valid = 1'b1; req_addr = ~a; req_io = ~io; req_write = ~wr;
    end
    for (int i = 1; i <= ew; i++) begin
      step();
      req_valid = 1'b0;
      chk(strobes() == exp_strobes(io, wr), "R3", "strobe held in wait",
          strobes(), exp_strobes(io, wr));
      chk(done == 1'b0, "R3", "no done in wait", done, 0);
      bus_rdy = (i >= nlow);
    end
    step();
    req_valid = 1'b0;
    // C3
    chk(strobes() == exp_strobes(io, wr), "R5", "strobe in C3", strobes(), exp_strobes(io, wr));
    chk(done == 1'b0, "R3", "no done in C3", done, 0);
    bus_din = rd;
    bus_rdy = 1'b1;
    step();
    // C4
    chk(done == 1'b1, "R2", "done in C4", done, 1);
    chk(strobes() == 4'b1111, "R9", "strobes released in C4", strobes(), 4'hf);
    chk(timeout == (nlow > MAX_WAITS), "R4", "timeout flag", timeout, (nlow > MAX_WAITS));
    chk(bus_addr == ea, "R10", "address held in C4", bus_addr, ea);
    chk(bus_doe == wr, "R7", "doe in C4", bus_doe, wr);
    if (wr) chk(bus_dout == wd, "R7", "write byte", bus_dout, wd);
    else    chk(rdata == rd, "R8", "read byte", rdata, rd);
    bus_din = ~rd;
    step();
    // idle
    chk(busy == 1'b0, "R10", "idle after C4", busy, 0);
    chk(done == 1'b0, "R8", "done one clock", done, 0);
    chk(bus_doe == 1'b0, "R7", "doe idle", bus_doe, 0);
    chk(strobes() == 4'b1111, "R9", "strobes idle", strobes(), 4'hf);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_io = 1'b0;
    req_addr = '0; req_wdata = '0; bus_din = '0; bus_rdy = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(strobes() == 4'b1111, "R1", "reset strobes", strobes(), 4'hf);
    chk(!bus_ale && !bus_doe && !done && !timeout && !busy, "R1", "reset flags",
        {bus_ale, bus_doe, done, timeout, busy}, 0);

    // directed corner cases
    run_txn(1'b0, 1'b0, 20'hABCDE, 8'h00, 0, 8'h5A, 1'b0);            // R5 memory read
    run_txn(1'b1, 1'b0, 20'h12345, 8'hC3, 0, 8'h00, 1'b1);            // R5 memory write, R10 poke
    run_txn(1'b0, 1'b1, 20'hF8765, 8'h00, 2, 8'hA7, 1'b0);            // R6 I/O read, R3 waits
    run_txn(1'b1, 1'b1, 20'hFFFFF, 8'h3C, 1, 8'h00, 1'b0);            // R6 I/O write
    run_txn(1'b0, 1'b0, 20'h00001, 8'h00, MAX_WAITS, 8'h96, 1'b0);    // R4 exactly at cap
    run_txn(1'b0, 1'b1, 20'h0BEEF, 8'h00, MAX_WAITS + 1, 8'h69, 1'b0); // R4 timeout
    run_txn(1'b1, 1'b0, 20'h80000, 8'hFF, MAX_WAITS + 3, 8'h00, 1'b1); // R4 timeout write

    // constrained random
    void'($urandom(32'd2024));
    for (int k = 0; k < 60; k++) begin
      run_txn(1'($urandom), 1'($urandom), 20'($urandom), 8'($urandom),
              int'($urandom % (MAX_WAITS + 3)), 8'($urandom), 1'($urandom));
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule